// File: doc/BRIEF.md
# Supervisor Reset and Software Watchdog

This block produces the processor reset pair and runs a software watchdog for a small system. All timing is counted in ticks of a single clock-enable input. An external comparator reports whether the supply is within tolerance. While it is not, both resets are held active and a threshold indicator is raised. Once the supply recovers, the resets are stretched for a fixed number of ticks so that the processor starts cleanly. An already-synchronised pushbutton request starts the same stretched pulse.

After reset, software must produce falling edges on a strobe line. If no falling edge arrives within the timeout, the block raises a latched active-low watchdog status and issues a new reset pulse. The first period after any reset is four times longer than later periods, which gives boot code extra time. A separate flag says whether the strobe is connected at all. When it is clear, the watchdog is off, in the same way as an unconnected pin.

Top module: `supv_wdog_ctrl`

## Requirements
- R1: On the first clock edge at which `supply_ok` is sampled low, `cpu_rst` becomes 1, `thr_low` becomes 1 and `wd_stat_n` becomes 0. They stay so while `supply_ok` stays low.
- R2: On the first edge at which `supply_ok` is sampled high again, `thr_low` becomes 0. `cpu_rst` stays 1 until exactly `RST_TICKS` further ticks have been counted and falls on the edge that counts the last of them.
- R3: `cpu_rst_n` is always the exact complement of `cpu_rst`. Both are registered.
- R4: A sampled-high `pb_req` sets `cpu_rst` on that edge and reloads the pulse length. `cpu_rst` falls `RST_TICKS` ticks after the last edge at which the request was sampled, so a request during a pulse restarts the pulse.
- R5: The first watchdog period after a reset release is `NORM_TICKS*4` ticks. With a tick on every cycle and no strobe edge, the timeout occurs on the edge that lies that many edges after the edge at which `cpu_rst` fell.
- R6: A falling edge on `strobe` reaches the watchdog through a two-flop synchroniser and one edge-detect flop. The counter restarts on the third edge after `strobe` is first sampled low. Every later period is `NORM_TICKS` ticks.
- R7: A steady `strobe` level, whether high or low, never restarts the watchdog.
- R8: A timeout drives `wd_stat_n` to 0 and sets `cpu_rst` on the same edge. A reset pulse of `RST_TICKS` ticks follows.
- R9: `wd_stat_n` stays 0 until a detected strobe falling edge with the supply good sets it back to 1, three edges after `strobe` is first sampled low. It does not clear when the supply returns or when a reset pulse ends.
- R10: No timeout occurs while `strobe_conn` is 0 or `supply_ok` is 0. The count is held at zero, so after re-enable a full period is needed.
- R11: Reset-pulse and watchdog counts advance only on cycles with `tick_en` high.
- R12: During the asynchronous reset `rst_n` = 0: `cpu_rst` = 1, `cpu_rst_n` = 0, `thr_low` = 1, `wd_stat_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timing tick, one cycle per count |
| supply_ok | input | 1 | Supply within tolerance (from comparator) |
| pb_req | input | 1 | Synchronised pushbutton reset request |
| strobe | input | 1 | Asynchronous watchdog strobe; falling edge kicks |
| strobe_conn | input | 1 | Strobe present; 0 disables the watchdog |
| cpu_rst | output | 1 | Processor reset, active high |
| cpu_rst_n | output | 1 | Processor reset, active low |
| thr_low | output | 1 | Supply below reset threshold |
| wd_stat_n | output | 1 | Latched watchdog status, active low |

## Verification
The bench builds the block with `RST_TICKS` = 5 and `NORM_TICKS` = 4, which gives a first watchdog period of 16 ticks. With these values every pulse, timeout and restart edge can be predicted edge by edge, and the bench checks each one at the exact edge and the edge before it. The small counts also allow tests of back-to-back timeouts, fast strobe trains at the period limit, long disabled stretches of several periods, stalled ticks, and nested pushbutton requests, all within a few hundred cycles.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // Counter width able to hold values 0..max_val
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/supv_strobe_edge.sv
module supv_strobe_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic strobe_fall
);
  localparam int unsigned CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN-2:0], strobe};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  // High for one cycle after the synchronised level goes from 1 to 0
  assign strobe_fall = chain_q[CHAIN-1] & ~chain_q[CHAIN-2];
endmodule

// File: rtl/supv_rst_pulse.sv
module supv_rst_pulse #(
  parameter int unsigned RST_TICKS = 641
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic load,
  output logic pulse_next
);
  localparam int unsigned W = supv_pkg::cnt_width(RST_TICKS);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)                          cnt_d = W'(RST_TICKS);
    else if (tick_en && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                               cnt_d = cnt_q;
  end

  assign pulse_next = (cnt_d != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(RST_TICKS);
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/supv_wdog_timer.sv
module supv_wdog_timer #(
  parameter int unsigned NORM_TICKS = 5120,
  parameter int unsigned FIRST_MULT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic enable,
  input  logic restart,
  input  logic rst_active,
  output logic timeout
);
  localparam int unsigned FIRST_TICKS = NORM_TICKS * FIRST_MULT;
  localparam int unsigned W = supv_pkg::cnt_width(FIRST_TICKS);

  logic [W-1:0] cnt_q, cnt_d;
  logic         first_q, first_d;
  logic [W-1:0] period_end;

  assign period_end = first_q ? W'(FIRST_TICKS - 1) : W'(NORM_TICKS - 1);
  assign timeout    = enable && !restart && tick_en && (cnt_q == period_end);

  always_comb begin
    cnt_d   = cnt_q;
    first_d = first_q;
    if (rst_active) begin
      cnt_d   = '0;
      first_d = 1'b1;
    end else if (!enable) begin
      cnt_d   = '0;
    end else if (restart) begin
      cnt_d   = '0;
      first_d = 1'b0;
    end else if (tick_en) begin
      cnt_d   = timeout ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      first_q <= first_d;
    end
  end
endmodule

// File: rtl/supv_wdog_ctrl.sv
module supv_wdog_ctrl #(
  parameter int unsigned RST_TICKS   = 641,
  parameter int unsigned NORM_TICKS  = 5120,
  parameter int unsigned FIRST_MULT  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic supply_ok,
  input  logic pb_req,
  input  logic strobe,
  input  logic strobe_conn,
  output logic cpu_rst,
  output logic cpu_rst_n,
  output logic thr_low,
  output logic wd_stat_n
);
  logic strobe_fall;
  logic wd_timeout;
  logic pulse_next;
  logic pulse_load;
  logic wd_enable;

  logic cpu_rst_q, cpu_rst_n_q, thr_q, wds_q;
  logic thr_d, wds_d;

  supv_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) strobe_edge_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .strobe_fall (strobe_fall)
  );

  assign pulse_load = ~supply_ok | pb_req | wd_timeout;

  supv_rst_pulse #(.RST_TICKS(RST_TICKS)) rst_pulse_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .load       (pulse_load),
    .pulse_next (pulse_next)
  );

  assign wd_enable = strobe_conn & supply_ok & ~cpu_rst_q;

  supv_wdog_timer #(.NORM_TICKS(NORM_TICKS), .FIRST_MULT(FIRST_MULT)) wdog_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .enable     (wd_enable),
    .restart    (strobe_fall),
    .rst_active (cpu_rst_q),
    .timeout    (wd_timeout)
  );

  always_comb begin
    thr_d = ~supply_ok;
    if (!supply_ok)       wds_d = 1'b0;
    else if (wd_timeout)  wds_d = 1'b0;
    else if (strobe_fall) wds_d = 1'b1;
    else                  wds_d = wds_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rst_q   <= 1'b1;
      cpu_rst_n_q <= 1'b0;
      thr_q       <= 1'b1;
      wds_q       <= 1'b1;
    end else begin
      cpu_rst_q   <= pulse_next;
      cpu_rst_n_q <= ~pulse_next;
      thr_q       <= thr_d;
      wds_q       <= wds_d;
    end
  end

  assign cpu_rst   = cpu_rst_q;
  assign cpu_rst_n = cpu_rst_n_q;
  assign thr_low   = thr_q;
  assign wd_stat_n = wds_q;
endmodule

// File: rtl/supv_wdog_ctrl_chk.sv
module supv_wdog_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_en,
  input logic supply_ok,
  input logic pb_req,
  input logic strobe_conn,
  input logic cpu_rst,
  input logic cpu_rst_n,
  input logic thr_low,
  input logic wd_stat_n
);
  // R3
  rst_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_n == !cpu_rst);

  // R1
  supply_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (cpu_rst && thr_low && !wd_stat_n));

  // R2
  thr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok |=> !thr_low);

  // R4
  pb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_req |=> cpu_rst);

  // R8
  timeout_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_stat_n) |-> cpu_rst);

  // R9
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_stat_n) |-> $past(supply_ok));

  // R10
  no_timeout_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wd_stat_n) && $past(supply_ok)) |-> $past(strobe_conn));

  // R11
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rst && !tick_en && supply_ok && !pb_req) |=> cpu_rst);
endmodule

bind supv_wdog_ctrl supv_wdog_ctrl_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .supply_ok   (supply_ok),
  .pb_req      (pb_req),
  .strobe_conn (strobe_conn),
  .cpu_rst     (cpu_rst),
  .cpu_rst_n   (cpu_rst_n),
  .thr_low     (thr_low),
  .wd_stat_n   (wd_stat_n)
);

// File: tb/supv_wdog_ctrl_tb.sv
module supv_wdog_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int R = 5;
  localparam int N = 4;
  localparam int F = N * 4;

  logic clk = 1'b0;
  logic rst_n, tick_en, supply_ok, pb_req, strobe, strobe_conn;
  logic cpu_rst, cpu_rst_n, thr_low, wd_stat_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supv_wdog_ctrl #(.RST_TICKS(R), .NORM_TICKS(N), .FIRST_MULT(4), .SYNC_STAGES(2)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .supply_ok   (supply_ok),
    .pb_req      (pb_req),
    .strobe      (strobe),
    .strobe_conn (strobe_conn),
    .cpu_rst     (cpu_rst),
    .cpu_rst_n   (cpu_rst_n),
    .thr_low     (thr_low),
    .wd_stat_n   (wd_stat_n)
  );

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      summary();
      $finish;
    end
  end

  initial begin
    bit bad;
    rst_n = 1'b0; tick_en = 1'b1; supply_ok = 1'b0; pb_req = 1'b0;
    strobe = 1'b1; strobe_conn = 1'b1;
    #(CLK_PERIOD * 3);
    // R12 reset state
    chk("R12", "cpu_rst",   cpu_rst,   1);
    chk("R12", "cpu_rst_n", cpu_rst_n, 0);
    chk("R12", "thr_low",   thr_low,   1);
    chk("R12", "wd_stat_n", wd_stat_n, 1);
    @(negedge clk); rst_n = 1'b1;
    edges(3);
    // R1 supply below threshold
    chk("R1", "cpu_rst",   cpu_rst,   1);
    chk("R1", "thr_low",   thr_low,   1);
    chk("R1", "wd_stat_n", wd_stat_n, 0);

    // R2 supply return, stretched reset
    supply_ok = 1'b1;
    edges(1);
    chk("R2", "thr_low", thr_low, 0);
    edges(R - 2);
    chk("R2", "cpu_rst before end", cpu_rst, 1);
    edges(1);
    chk("R2", "cpu_rst at end", cpu_rst, 0);
    chk("R3", "cpu_rst_n", cpu_rst_n, 1);
    chk("R9", "status stays latched", wd_stat_n, 0);

    // R5 first long period
    edges(F - 1);
    chk("R5", "no timeout before first period", cpu_rst, 0);
    edges(1);
    chk("R5", "timeout at first period", cpu_rst, 1);
    edges(R - 1);
    chk("R8", "pulse held", cpu_rst, 1);
    edges(1);
    chk("R8", "pulse released", cpu_rst, 0);

    // R9 / R6 strobe fall clears status and restarts with short period
    strobe = 1'b0;
    edges(2);
    chk("R9", "not cleared yet", wd_stat_n, 0);
    edges(1);
    chk("R9", "cleared by strobe fall", wd_stat_n, 1);
    edges(N - 1);
    chk("R6", "no timeout before normal period", cpu_rst, 0);
    chk("R6", "status still clear", wd_stat_n, 1);
    edges(1);
    chk("R8", "status latched low on timeout", wd_stat_n, 0);
    chk("R6", "timeout after normal period", cpu_rst, 1);
    chk("R3", "cpu_rst_n complement", cpu_rst_n, 0);
    edges(R);
    chk("R8", "release after timeout", cpu_rst, 0);

    // R7 steady low strobe does nothing
    edges(F - 1);
    chk("R7", "no restart from low level", cpu_rst, 0);
    edges(1);
    chk("R7", "timeout with steady low strobe", cpu_rst, 1);
    edges(R);
    chk("R7", "released", cpu_rst, 0);

    // R6 fast strobe train keeps the watchdog quiet
    strobe = 1'b1;
    bad = 1'b0;
    for (int i = 0; i < 40; i++) begin
      edges(1);
      strobe = ~strobe;
      if (cpu_rst) bad = 1'b1;
    end
    edges(3);
    chk("R6", "no timeout with strobe train", int'(bad), 0);
    chk("R9", "status cleared by train", wd_stat_n, 1);

    // R10 disconnected strobe disables the watchdog
    strobe_conn = 1'b0;
    edges(3 * F);
    chk("R10", "no timeout while disconnected", cpu_rst, 0);
    chk("R10", "status untouched", wd_stat_n, 1);
    strobe_conn = 1'b1;
    edges(N - 1);
    chk("R10", "full period after reconnect", cpu_rst, 0);
    edges(1);
    chk("R10", "timeout after reconnect", cpu_rst, 1);
    edges(R);
    chk("R10", "released", cpu_rst, 0);

    // R4 pushbutton, restart during pulse; R11 tick gating
    pb_req = 1'b1;
    edges(1);
    chk("R4", "pushbutton asserts reset", cpu_rst, 1);
    pb_req = 1'b0;
    edges(2);
    pb_req = 1'b1;
    edges(1);
    pb_req = 1'b0;
    tick_en = 1'b0;
    edges(20);
    chk("R11", "no release without ticks", cpu_rst, 1);
    tick_en = 1'b1;
    edges(R - 1);
    chk("R4", "pulse restarted, still held", cpu_rst, 1);
    edges(1);
    chk("R4", "released after last request", cpu_rst, 0);

    // R1 / R10 supply fault while running
    supply_ok = 1'b0;
    edges(1);
    chk("R1", "cpu_rst on fault", cpu_rst, 1);
    chk("R1", "thr_low on fault", thr_low, 1);
    chk("R1", "wd_stat_n on fault", wd_stat_n, 0);
    edges(3 * F);
    chk("R10", "reset held during long fault", cpu_rst, 1);
    supply_ok = 1'b1;
    edges(R);
    chk("R2", "release after fault", cpu_rst, 0);
    chk("R9", "status stays low after fault", wd_stat_n, 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule